// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received Ethernet frame, whether its destination address is one the station wants to see. The receive path hands over the full 48-bit destination address with a one-cycle strobe. One clock later the filter returns an accept decision and a six-bit status word, which the receive path can copy into the frame's descriptor.

Four exact-match slots are compared against the address in parallel. Slot 0 is meant for the station's own address. A 64-bin hash table catches multicast groups that do not fit in the slots; the bin is chosen from the reflected Ethernet CRC-32 of the address. Two mode inputs widen the filter: one accepts every multicast frame and the other accepts every frame.

Top module: `rx_addr_filter`

## Requirements
- R1: `res_valid` is high for exactly the one cycle after each clock edge at which `da_valid` was high. `res_accept` and `res_status` carry that address's result and hold it until the next strobe.
- R2: An address of all 48 ones sets status bit 5 (broadcast), leaves bit 4 clear and is accepted.
- R3: An address with `da_addr[0]` set (bit 0 of the first byte on the wire, where `da_addr[7:0]` is that first byte) and not all ones sets status bit 4 (multicast).
- R4: Slot k occupies `cfg_exact_addr[48k+47:48k]` and uses the same byte layout as `da_addr`. An address equal to a valid slot sets status bit 2 and is accepted.
- R5: A slot whose 48 bits are all ones is unused and never matches, not even the broadcast address.
- R6: Status bits 1:0 give the lowest-numbered matching slot. They read 0 when no slot matches.
- R7: The hash value h is bits 31:26 of the CRC-32 over the six address bytes. The CRC is computed least significant bit first, with the reflected polynomial 0xEDB88320, a start value of all ones and no final inversion. The table bit used is `cfg_hash_tbl[16*h[5:4] + 15 - h[3:0]]`. Status bit 3 is set only for a multicast address whose table bit is one, and such a frame is accepted.
- R8: With `cfg_all_multi` set, every multicast address is accepted whatever the hash table holds.
- R9: With `cfg_promisc` set, every address is accepted.
- R10: An address that meets none of the conditions in R2, R4, R7, R8 or R9 is rejected (`res_accept` low). This includes a unicast address whose table bit happens to be set, and its status bit 3 stays clear.
- R11: While reset is asserted and after it is released, `res_valid` and `res_accept` are low until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_all_multi | input | 1 | Accept every multicast frame |
| cfg_exact_addr | input | 192 | Four exact-match slots, 48 bits each; slot 0 is the station address |
| cfg_hash_tbl | input | 64 | Multicast hash table: four 16-bit words, word w at bits 16w+15:16w |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address; bits 7:0 are the first byte on the wire |
| res_valid | output | 1 | Result pulse, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_status | output | 6 | Bit 5 broadcast, bit 4 multicast, bit 3 hash hit, bit 2 exact hit, bits 1:0 slot index |

## Verification
The bench programs the same address into slots 1 and 3. A priority encoder that lets the higher slot win would report index 3 instead of 1. It sends the broadcast address while a slot holds all ones: a filter that does not skip unused slots would raise the exact-hit flag on broadcast. It fills the hash table with ones and sends a unicast address, which a filter that ignores the group bit would accept and flag. It also derives the bin for a chosen multicast address with its own CRC routine and sets only that bit. A wrong CRC bit order, or a table word whose bit order is not reversed, would then miss the frame.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W   = 48;
  localparam int CRC_W   = 32;
  localparam int HASH_W  = 6;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  // Reflected CRC-32, LSB of byte 0 first, preset ones, no final inversion.
  function automatic logic [CRC_W-1:0] crc32_refl(input logic [MAC_W-1:0] a);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < MAC_W; i++) begin
      fb = c[0] ^ a[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

  function automatic logic [HASH_W-1:0] hash_of(input logic [MAC_W-1:0] a);
    logic [CRC_W-1:0] c;
    c = crc32_refl(a);
    return c[CRC_W-1 -: HASH_W];
  endfunction

  // Word h[5:4], bit 15 - h[3:0] inside that word.
  function automatic logic [HASH_W-1:0] table_pos(input logic [HASH_W-1:0] h);
    return {h[5:4], ~h[3:0]};
  endfunction
endpackage

// File: rtl/rxaf_exact_match.sv
module rxaf_exact_match #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS*rxaf_pkg::MAC_W-1:0] slots,
  input  logic [rxaf_pkg::MAC_W-1:0]           addr,
  output logic                                 hit,
  output logic [IDX_W-1:0]                     idx
);
  localparam int AW = rxaf_pkg::MAC_W;

  logic [NUM_SLOTS-1:0] slot_eq;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic [AW-1:0] ent;
      assign ent        = slots[g*AW +: AW];
      assign slot_eq[g] = (ent != {AW{1'b1}}) && (ent == addr);
    end
  endgenerate

  // Lowest index wins: scan downward so the last write is the lowest.
  always_comb begin
    hit = |slot_eq;
    idx = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--)
      if (slot_eq[k]) idx = IDX_W'(k);
  end
endmodule

// File: rtl/rxaf_hash_lookup.sv
module rxaf_hash_lookup #(
  parameter int TBL_BITS = 64
) (
  input  logic [TBL_BITS-1:0]        tbl,
  input  logic [rxaf_pkg::MAC_W-1:0] addr,
  output logic [rxaf_pkg::HASH_W-1:0] hash_val,
  output logic                       tbl_bit
);
  import rxaf_pkg::*;

  logic [HASH_W-1:0] pos;

  always_comb begin
    hash_val = hash_of(addr);
    pos      = table_pos(hash_val);
    tbl_bit  = tbl[pos];
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_SLOTS = 4,
  parameter int TBL_BITS  = 64,
  localparam int AW       = rxaf_pkg::MAC_W,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int STAT_W   = 4 + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_promisc,
  input  logic                    cfg_all_multi,
  input  logic [NUM_SLOTS*AW-1:0] cfg_exact_addr,
  input  logic [TBL_BITS-1:0]     cfg_hash_tbl,
  input  logic                    da_valid,
  input  logic [AW-1:0]           da_addr,
  output logic                    res_valid,
  output logic                    res_accept,
  output logic [STAT_W-1:0]       res_status
);
  localparam int B_BCAST = STAT_W - 1;
  localparam int B_MCAST = STAT_W - 2;
  localparam int B_HASH  = STAT_W - 3;
  localparam int B_EXACT = STAT_W - 4;

  // Named internal events
  logic                        is_bcast_w, is_mcast_w;
  logic                        exact_hit_w, tbl_bit_w, hash_hit_w;
  logic [IDX_W-1:0]            exact_idx_w;
  logic [rxaf_pkg::HASH_W-1:0] hash_val_w;
  logic                        accept_w;

  assign is_bcast_w = &da_addr;
  assign is_mcast_w = da_addr[0] & ~is_bcast_w;

  rxaf_exact_match #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_exact (
    .slots (cfg_exact_addr),
    .addr  (da_addr),
    .hit   (exact_hit_w),
    .idx   (exact_idx_w)
  );

  rxaf_hash_lookup #(.TBL_BITS(TBL_BITS)) u_hash (
    .tbl      (cfg_hash_tbl),
    .addr     (da_addr),
    .hash_val (hash_val_w),
    .tbl_bit  (tbl_bit_w)
  );

  assign hash_hit_w = is_mcast_w & tbl_bit_w;
  assign accept_w   = cfg_promisc | is_bcast_w | exact_hit_w
                    | (is_mcast_w & (hash_hit_w | cfg_all_multi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_status <= '0;
    end else begin
      res_valid <= da_valid;
      if (da_valid) begin
        res_accept <= accept_w;
        res_status <= {is_bcast_w, is_mcast_w, hash_hit_w, exact_hit_w, exact_idx_w};
      end
    end
  end

  // Assertions
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(da_valid)));
  p_bcast_not_mcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[B_BCAST] |-> !res_status[B_MCAST]);
  p_exact_accepts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[B_EXACT] |-> res_accept);
  p_idx_zero_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_status[B_EXACT] |-> (res_status[IDX_W-1:0] == '0));
  p_hash_needs_mcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[B_HASH] |-> (res_status[B_MCAST] && res_accept));
  p_promisc_accepts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_promisc) |=> res_accept);
  p_held_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(da_valid) |-> ($stable(res_accept) && $stable(res_status)));
endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
  localparam logic [47:0] ONES = {48{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_promisc = 1'b0;
  logic         cfg_all_multi = 1'b0;
  logic [191:0] cfg_exact_addr = {192{1'b1}};
  logic [63:0]  cfg_hash_tbl = '0;
  logic         da_valid = 1'b0;
  logic [47:0]  da_addr = '0;
  logic         res_valid, res_accept;
  logic [5:0]   res_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk, .rst_n, .cfg_promisc, .cfg_all_multi, .cfg_exact_addr, .cfg_hash_tbl,
    .da_valid, .da_addr, .res_valid, .res_accept, .res_status
  );

  // Byte-wise reflected CRC, bin from the top six bits
  function automatic int bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[8*b +: 8];
      c = c ^ {24'd0, by};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return int'(c >> 26);
  endfunction

  function automatic int tbl_index(input int h);
    return (h / 16) * 16 + (15 - (h % 16));
  endfunction

  function automatic logic [6:0] model(input logic [47:0] a);
    logic bc, mc, hh, eh, acc;
    logic [1:0] ix = 2'd0;
    bc = (a == ONES);
    mc = a[0] && !bc;
    eh = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      logic [47:0] e = cfg_exact_addr[48*k +: 48];
      if (e != ONES && e == a) begin eh = 1'b1; ix = 2'(k); end
    end
    hh  = mc && cfg_hash_tbl[tbl_index(bin_of(a))];
    acc = cfg_promisc || bc || eh || (mc && (hh || cfg_all_multi));
    return {acc, bc, mc, hh, eh, ix};
  endfunction

  task automatic send(input logic [47:0] a, input string tag);
    @(negedge clk);
    da_valid = 1'b1;
    da_addr  = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    @(negedge clk);
    da_valid = 1'b0;
    da_addr  = '0;
  endtask

  task automatic expect_and_send(input logic [47:0] a, input logic [6:0] want, input string tag);
    n_cmp++;
    if (model(a) !== want) begin
      n_bad++;
      $display("FAIL %s model: actual %b expected %b", tag, model(a), want);
    end
    send(a, tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [6:0] e;
      string t;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected result: actual %b expected none", {res_accept, res_status});
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({res_accept, res_status} !== e) begin
          n_bad++;
          $display("FAIL %s: actual %b expected %b", t, {res_accept, res_status}, e);
        end
      end
    end
  end

  initial begin
    logic [47:0] sta  = 48'h5544_3322_1100;
    logic [47:0] uc2  = 48'hA0B0_C0D0_E0F2;
    logic [47:0] dup  = 48'h0102_0304_0506;
    logic [47:0] grpA = 48'h0000_5E00_0001;
    logic [47:0] grpB = 48'hFB00_005E_0001;
    logic [47:0] miss = 48'h7766_5544_3322;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_cmp++;
    if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 in reset: actual %b%b expected 00", res_valid, res_accept);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 after reset: actual %b%b expected 00", res_valid, res_accept);
    end

    cfg_exact_addr[0 +: 48]   = sta;
    cfg_exact_addr[96 +: 48]  = uc2;
    send(sta,  "R4 station slot 0");
    send(uc2,  "R4 R6 slot 2 index");
    expect_and_send(miss, 7'b0_000000, "R10 unicast miss rejected");
    // R2/R5: slot 1 and 3 all ones, broadcast gives no exact hit
    expect_and_send(ONES, 7'b1_100000, "R2 R5 broadcast, unused slots");
    // R6 duplicate slots -> lowest index
    cfg_exact_addr[48 +: 48]  = dup;
    cfg_exact_addr[144 +: 48] = dup;
    expect_and_send(dup, 7'b1_000101, "R6 lowest index wins");
    // R7 hash hit: set only grpA's bin
    cfg_hash_tbl = '0;
    cfg_hash_tbl[tbl_index(bin_of(grpA))] = 1'b1;
    expect_and_send(grpA, 7'b1_011000, "R7 R3 multicast hash hit");
    send(grpB, "R7 R10 other multicast");
    cfg_hash_tbl = ~cfg_hash_tbl;
    expect_and_send(grpA, 7'b0_010000, "R7 R10 hash bin clear");
    // R10 unicast with full table
    cfg_hash_tbl = '1;
    expect_and_send(miss, 7'b0_000000, "R10 unicast ignores table");
    cfg_hash_tbl = '0;
    // R8 all-multicast
    cfg_all_multi = 1'b1;
    expect_and_send(grpB, 7'b1_010000, "R8 all multicast");
    expect_and_send(miss, 7'b0_000000, "R8 unicast still rejected");
    cfg_all_multi = 1'b0;
    // R9 promiscuous
    cfg_promisc = 1'b1;
    expect_and_send(miss, 7'b1_000000, "R9 promiscuous unicast");
    send(grpB, "R9 promiscuous multicast");
    cfg_promisc = 1'b0;
    // R1 back-to-back strobes
    @(negedge clk);
    da_valid = 1'b1; da_addr = sta;
    exp_q.push_back(model(sta)); tag_q.push_back("R1 back-to-back first");
    @(negedge clk);
    da_addr = miss;
    exp_q.push_back(model(miss)); tag_q.push_back("R1 back-to-back second");
    @(negedge clk);
    da_valid = 1'b0; da_addr = '0;
    repeat (3) @(negedge clk);
    // R1 hold after pulse
    n_cmp++;
    if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_status !== 6'b000000) begin
      n_bad++;
      $display("FAIL R1 hold: actual %b%b%b expected 0 0 000000", res_valid, res_accept, res_status);
    end
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing results: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule